// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block is the capture-side control of a sixteen-channel logic analyzer. A byte-wide register file, reached over a plain address/data bus with separate write and read strobes, holds a control/status byte, a sixteen-bit channel-enable mask split over two bytes, a divider byte and a base-clock select byte. From these it produces a one-cycle sample-enable strobe at the chosen base rate divided by the programmed factor. It also checks that the number of enabled channels does not exceed what the resulting sample rate allows.

Both base references (100 MHz and 160 MHz) are modelled as clock-enable tick streams inside one core clock domain, nominally 160 MHz. Software first arms the block, then writes the configuration registers and commits them with a fixed handshake on the control byte. Capture is then started and later stopped, and each step is confirmed by a fixed readback code. Configuration bytes may be rewritten at any time, but the strobe generator only uses the values captured at the last commit.

Top module: `lacq_top`

## Requirements
- R1: After reset, and after any stop, reading address 1 returns 0x08.
- R2: From idle, writing 0x40 to address 1 arms configuration and address 1 reads 0x40. Writing 0x42 then commits and reads 0x4A. Writing 0x40 again reads 0x48 (configured).
- R3: Writing 0x41 to address 1 while configured (0x48) starts capture and address 1 reads 0x49. In any other state, 0x41 is ignored.
- R4: Writing 0x00 to address 1 from any state returns to idle. The strobe stops and the error flag clears.
- R5: Addresses 2 (channels 0-7, bit n = channel n), 3 (channels 8-15), 4 (divider minus one) and 10 (base select) read back the full byte last written.
- R6: Reads of any other address return 0x00, and writes to them change no register.
- R7: A read returns its data with rdValid high in the cycle after rdEn, and rdValid is low otherwise.
- R8: While capturing, one strobe is issued every (div+1) base ticks, where div is the address 4 value latched at the last commit. Later writes to address 4 have no effect until the next commit.
- R9: Bit 0 of address 10 picks the base. With 0, the 100 MHz reference gives 5 ticks in every 8 core cycles. With 1, the 160 MHz reference gives a tick every core cycle.
- R10: sampleStrobe is low in every state other than capturing.
- R11: At commit, errFlag is set if the base rate divided by (div+1) exceeds the channel-count limit. The limit is 100 MHz below 4 enabled channels, and 50, 40, 32, 25 and 16 MHz from 4, 7, 8, 10 and 13 enabled channels upward. Once set, the flag stays set until a 0x00 write to address 1.
- R12: Writing 0x40 to address 1 while capturing stops the strobe and address 1 reads 0x48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (160 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| sampleStrobe | output | 1 | One-cycle sample enable |
| errFlag | output | 1 | Channel-count versus rate violation, latched |

## Verification
The hardest situations to reach are the rate limit boundaries. Each one needs a mask with exactly the threshold number of channels, paired with a divider that puts the rate just above or just below that tier's limit, and all of it has to be committed through the full handshake. The bench builds each such pair directly. Examples are four channels at 160/3 and 160/4 MHz, thirteen channels at 100/6 and 100/7 MHz, and three channels at the undivided 160 MHz. After each commit it reads errFlag, then starts capture and counts strobes over windows that are whole multiples of the tick pattern. That makes the expected count exact on both bases, and it also covers a divider rewritten without a commit.

// File: rtl/lacq_pkg.sv
package lacq_pkg;

  localparam logic [7:0] ADDR_CTRL = 8'd1;
  localparam logic [7:0] ADDR_MLO  = 8'd2;
  localparam logic [7:0] ADDR_MHI  = 8'd3;
  localparam logic [7:0] ADDR_DIV  = 8'd4;
  localparam logic [7:0] ADDR_SEL  = 8'd10;

  localparam logic [7:0] CMD_STOP  = 8'h00;
  localparam logic [7:0] CMD_ARM   = 8'h40;
  localparam logic [7:0] CMD_START = 8'h41;
  localparam logic [7:0] CMD_APPLY = 8'h42;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_APPLY,
    ST_CFG,
    ST_RUN
  } ctlState_t;

  typedef struct packed {
    logic apply;
    logic run;
    logic clearErr;
  } ctlStrobe_t;

  function automatic logic [7:0] statusCode(ctlState_t s);
    case (s)
      ST_PEND:  return 8'h40;
      ST_APPLY: return 8'h4A;
      ST_CFG:   return 8'h48;
      ST_RUN:   return 8'h49;
      default:  return 8'h08;
    endcase
  endfunction

  function automatic int unsigned chanLimitMhz(int unsigned n);
    if (n >= 13)     return 16;
    else if (n >= 10) return 25;
    else if (n >= 8)  return 32;
    else if (n >= 7)  return 40;
    else if (n >= 4)  return 50;
    else              return 100;
  endfunction

endpackage

// File: rtl/lacq_ctrl.sv
module lacq_ctrl
  import lacq_pkg::*;
#(
  parameter int AW = 8,
  parameter int CH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wrData,
  output logic [7:0]    rdData,
  output logic          rdValid,
  output ctlStrobe_t    ctlBus,
  output logic [CH-1:0] cfgMask,
  output logic [7:0]    cfgDiv,
  output logic          cfgSel
);

  localparam int HALF = CH / 2;

  ctlState_t  state, stateNext;
  logic [HALF-1:0] maskLo, maskHi;
  logic [7:0] divReg, selReg;
  logic       ctrlWr, applyNow, stopNow;

  assign ctrlWr   = wrEn && (addr == AW'(ADDR_CTRL));
  assign applyNow = ctrlWr && (wrData == CMD_APPLY) &&
                    (state == ST_PEND || state == ST_CFG || state == ST_APPLY);
  assign stopNow  = ctrlWr && (wrData == CMD_STOP);

  always_comb begin
    stateNext = state;
    if (ctrlWr) begin
      case (wrData)
        CMD_STOP: stateNext = ST_IDLE;
        CMD_ARM: begin
          if (state == ST_IDLE)      stateNext = ST_PEND;
          else if (state != ST_PEND) stateNext = ST_CFG;
        end
        CMD_APPLY: if (applyNow) stateNext = ST_APPLY;
        CMD_START: if (state == ST_CFG) stateNext = ST_RUN;
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      maskLo <= '0;
      maskHi <= '0;
      divReg <= '0;
      selReg <= '0;
      ctlBus <= '0;
    end else begin
      state           <= stateNext;
      ctlBus.apply    <= applyNow;
      ctlBus.clearErr <= stopNow;
      ctlBus.run      <= (stateNext == ST_RUN);
      if (wrEn) begin
        case (addr)
          AW'(ADDR_MLO): maskLo <= wrData[HALF-1:0];
          AW'(ADDR_MHI): maskHi <= wrData[HALF-1:0];
          AW'(ADDR_DIV): divReg <= wrData;
          AW'(ADDR_SEL): selReg <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) begin
        case (addr)
          AW'(ADDR_CTRL): rdData <= statusCode(state);
          AW'(ADDR_MLO):  rdData <= 8'(maskLo);
          AW'(ADDR_MHI):  rdData <= 8'(maskHi);
          AW'(ADDR_DIV):  rdData <= divReg;
          AW'(ADDR_SEL):  rdData <= selReg;
          default:        rdData <= 8'h00;
        endcase
      end
    end
  end

  assign cfgMask = {maskHi, maskLo};
  assign cfgDiv  = divReg;
  assign cfgSel  = selReg[0];

endmodule

// File: rtl/lacq_dp.sv
module lacq_dp
  import lacq_pkg::*;
#(
  parameter int CH       = 16,
  parameter int CORE_MHZ = 160,
  parameter int REF0_MHZ = 100,
  parameter int REF1_MHZ = 160
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    ctlBus,
  input  logic [CH-1:0] cfgMask,
  input  logic [7:0]    cfgDiv,
  input  logic          cfgSel,
  output logic          sampleStrobe,
  output logic          errFlag
);

  localparam int ACCW = $clog2(2 * CORE_MHZ + 1);

  logic [1:0] baseTick;

  for (genvar g = 0; g < 2; g++) begin : g_ref
    localparam int RATE = (g == 0) ? REF0_MHZ : REF1_MHZ;
    logic [ACCW-1:0] acc;
    logic [ACCW:0]   accSum;
    assign accSum      = {1'b0, acc} + (ACCW+1)'(RATE);
    assign baseTick[g] = (accSum >= (ACCW+1)'(CORE_MHZ));
    always_ff @(posedge clk) begin
      if (!rstN) acc <= '0;
      else if (baseTick[g]) acc <= ACCW'(accSum - (ACCW+1)'(CORE_MHZ));
      else acc <= ACCW'(accSum);
    end
  end

  logic [7:0] actDiv, divCnt;
  logic       actSel, tick;

  assign tick = actSel ? baseTick[1] : baseTick[0];

  logic        rateViol;
  int unsigned nChan, refRate, limProd;

  always_comb begin
    nChan    = $countones(cfgMask);
    refRate  = cfgSel ? REF1_MHZ : REF0_MHZ;
    limProd  = chanLimitMhz(nChan) * (32'(cfgDiv) + 1);
    rateViol = refRate > limProd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actDiv       <= '0;
      actSel       <= 1'b0;
      divCnt       <= '0;
      sampleStrobe <= 1'b0;
      errFlag      <= 1'b0;
    end else begin
      sampleStrobe <= 1'b0;
      if (ctlBus.apply) begin
        actDiv <= cfgDiv;
        actSel <= cfgSel;
        divCnt <= cfgDiv;
      end else if (ctlBus.run && tick) begin
        if (divCnt == 8'd0) begin
          sampleStrobe <= 1'b1;
          divCnt       <= actDiv;
        end else begin
          divCnt <= divCnt - 8'd1;
        end
      end
      if (ctlBus.clearErr) errFlag <= 1'b0;
      else if (ctlBus.apply && rateViol) errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/lacq_top.sv
module lacq_top
  import lacq_pkg::*;
#(
  parameter int AW       = 8,
  parameter int CH       = 16,
  parameter int CORE_MHZ = 160,
  parameter int REF0_MHZ = 100,
  parameter int REF1_MHZ = 160
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wrData,
  output logic [7:0]    rdData,
  output logic          rdValid,
  output logic          sampleStrobe,
  output logic          errFlag
);

  ctlStrobe_t    ctlBus;
  logic [CH-1:0] cfgMask;
  logic [7:0]    cfgDiv;
  logic          cfgSel;
  logic          runState, applyPulse;

  assign runState   = ctlBus.run;
  assign applyPulse = ctlBus.apply;

  lacq_ctrl #(.AW(AW), .CH(CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .ctlBus(ctlBus),
    .cfgMask(cfgMask), .cfgDiv(cfgDiv), .cfgSel(cfgSel)
  );

  lacq_dp #(.CH(CH), .CORE_MHZ(CORE_MHZ), .REF0_MHZ(REF0_MHZ),
            .REF1_MHZ(REF1_MHZ)) u_dp (
    .clk(clk), .rstN(rstN), .ctlBus(ctlBus), .cfgMask(cfgMask),
    .cfgDiv(cfgDiv), .cfgSel(cfgSel), .sampleStrobe(sampleStrobe),
    .errFlag(errFlag)
  );

endmodule

// File: rtl/lacq_chk.sv
module lacq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic          rdEn,
  input logic [AW-1:0] addr,
  input logic [7:0]    wrData,
  input logic          rdValid,
  input logic          sampleStrobe,
  input logic          errFlag,
  input logic          runState,
  input logic          applyPulse
);

  logic stopWr;
  assign stopWr = wrEn && (addr == AW'(1)) && (wrData == 8'h00);

  a_r7_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  a_r10_strobe_in_run: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(runState));

  a_r4_stop_halts: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> !runState);

  a_r4_err_cleared: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> ##1 !errFlag);

  a_r11_err_from_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(applyPulse));

endmodule

bind lacq_top lacq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_lacq_top.sv
module sim_lacq_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = '0, wrData = '0;
  logic [7:0] rdData;
  logic       rdValid, sampleStrobe, errFlag;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         done = 0;

  always #5 clk = ~clk;

  lacq_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .sampleStrobe(sampleStrobe), .errFlag(errFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rdValid) begin
      if (expQ.size() == 0) check(0, "R7 unexpected rdValid", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData == e, t, rdData, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic commit();
    wr(8'd1, 8'h40);
    wr(8'd1, 8'h42);
    wr(8'd1, 8'h40);
    repeat (3) @(negedge clk);
  endtask

  task automatic countStrobes(input int cycles, input int exp, input string tag);
    int n = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sampleStrobe) n++;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic errCase(input logic [15:0] mask, input logic sel,
                         input logic [7:0] div, input bit exp, input string tag);
    wr(8'd1, 8'h00);
    wr(8'd2, mask[7:0]);
    wr(8'd3, mask[15:8]);
    wr(8'd4, div);
    wr(8'd10, {7'd0, sel});
    commit();
    check(errFlag == exp, tag, errFlag, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sampleStrobe == 0 && errFlag == 0, "R10 reset outputs", sampleStrobe, 0);
    rd(8'd1, 8'h08, "R1 reset status");

    // R3: start ignored from idle
    wr(8'd1, 8'h41);
    rd(8'd1, 8'h08, "R3 start ignored in idle");

    // R2 handshake
    wr(8'd1, 8'h40);
    rd(8'd1, 8'h40, "R2 armed status");
    wr(8'd1, 8'h41);
    rd(8'd1, 8'h40, "R3 start ignored while armed");
    wr(8'd2, 8'h03); wr(8'd3, 8'h00); wr(8'd4, 8'h03); wr(8'd10, 8'h01);
    wr(8'd1, 8'h42);
    rd(8'd1, 8'h4A, "R2 commit status");
    wr(8'd1, 8'h40);
    rd(8'd1, 8'h48, "R2 configured status");

    // R5 readback
    rd(8'd2, 8'h03, "R5 mask low");
    wr(8'd3, 8'hA5);
    rd(8'd3, 8'hA5, "R5 mask high");
    wr(8'd3, 8'h00);
    rd(8'd4, 8'h03, "R5 divider");
    rd(8'd10, 8'h01, "R5 select");

    // R6 unimplemented
    wr(8'd5, 8'hFF);
    wr(8'd0, 8'hFF);
    rd(8'd5, 8'h00, "R6 unmapped read");
    rd(8'd0, 8'h00, "R6 unmapped read 0");
    rd(8'd2, 8'h03, "R6 write ignored mask");
    rd(8'd1, 8'h48, "R6 write ignored status");

    // R10 no strobes while configured
    countStrobes(40, 0, "R10 no strobe configured");

    // R3 run, R8/R9 sel1 div3
    wr(8'd1, 8'h41);
    rd(8'd1, 8'h49, "R3 running status");
    countStrobes(40, 10, "R8 R9 sel1 div3 count");
    // R8: divider write without commit
    wr(8'd4, 8'h07);
    countStrobes(40, 10, "R8 uncommitted divider ignored");

    // R12 arm while running
    wr(8'd1, 8'h40);
    rd(8'd1, 8'h48, "R12 status after arm in run");
    countStrobes(24, 0, "R12 strobe stopped");

    // R4 stop
    wr(8'd1, 8'h41);
    wr(8'd1, 8'h00);
    rd(8'd1, 8'h08, "R1 R4 status after stop");
    countStrobes(24, 0, "R4 R10 no strobe idle");

    // R9 sel0 div0: 5 ticks per 8 cycles
    wr(8'd4, 8'h00); wr(8'd10, 8'h00);
    commit();
    wr(8'd1, 8'h41);
    countStrobes(80, 50, "R9 sel0 div0 count");
    wr(8'd1, 8'h00);
    wr(8'd4, 8'h04);
    commit();
    wr(8'd1, 8'h41);
    countStrobes(80, 10, "R8 R9 sel0 div4 count");

    // R11 boundaries
    errCase(16'h000F, 1'b1, 8'd2, 1'b1, "R11 4ch 160/3 over 50");
    errCase(16'h000F, 1'b1, 8'd3, 1'b0, "R11 4ch 160/4 within 50");
    errCase(16'h1FFF, 1'b0, 8'd5, 1'b1, "R11 13ch 100/6 over 16");
    errCase(16'h1FFF, 1'b0, 8'd6, 1'b0, "R11 13ch 100/7 within 16");
    errCase(16'h0007, 1'b1, 8'd0, 1'b1, "R11 3ch 160 over 100");
    errCase(16'h0007, 1'b1, 8'd1, 1'b0, "R11 3ch 80 within 100");
    errCase(16'h00FF, 1'b1, 8'd4, 1'b0, "R11 8ch 32 at limit");
    // latch holds across a clean commit, clears on stop
    errCase(16'h03FF, 1'b1, 8'd5, 1'b1, "R11 10ch 26.7 over 25");
    wr(8'd4, 8'd9);
    commit();
    check(errFlag == 1'b1, "R11 flag stays latched", errFlag, 1);
    wr(8'd1, 8'h00);
    repeat (3) @(negedge clk);
    check(errFlag == 1'b0, "R4 stop clears flag", errFlag, 0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7 all reads answered", expQ.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule